// File: doc/BRIEF.md
# Correctable Error Leaky Bucket

This block keeps a running count of correctable errors and lets that count decay over time. An error event raises the count by one. A periodic leak pulse lowers it by one. A part that sees only rare, scattered errors therefore drifts back toward zero. A part that keeps producing errors builds up a count that a supervisor can compare against its own alarm level.

The leak rate comes from a wide free-running timer. A low-order prescaler produces one carry every 2^PRESC_W cycles, and only that carry advances a wide upper counter. Two one-hot configuration fields each pick one bit of the upper counter. When both picked bits read 1, the whole timer returns to zero and a single primary strobe is produced. A small secondary divider then merges one to four primary strobes into one leak pulse, according to a 2-bit code. If either threshold field is all zero, leaking is switched off.

The upper counter is brought out as a low half and a high half, so the aging timer can be observed.

Top module: `ce_leaky_bucket`

## Requirements
- R1: While leaking is enabled, the upper counter advances by exactly one per 2^PRESC_W clock cycles. Counting starts from zero, so after k cycles with no match it reads floor(k / 2^PRESC_W).
- R2: `upperLo` carries bits [UPPER_W/2-1:0] of the upper counter and `upperHi` carries the remaining high bits.
- R3: In the cycle where the upper-counter bit picked by `threshHi` and the bit picked by `threshLo` are both 1, one primary strobe is produced. At the next clock edge the whole timer, prescaler included, returns to zero.
- R4: `limitCode` sets how many primary strobes make one leak pulse: 2'b00 means 4, 2'b01 means 1, 2'b10 means 2, 2'b11 means 3. When both thresholds pick bit 0 and the timer and divider start from zero, leak pulses appear L*(2^PRESC_W+1) cycles after enable and every L*(2^PRESC_W+1) cycles after that.
- R5: `leakPulse` is high for exactly one cycle. It rises in the cycle after the primary strobe that completes a group.
- R6: A leak pulse with no error event lowers `errCount` by one at the next edge. At zero the count stays at zero.
- R7: An error event with no leak pulse raises `errCount` by one at the next edge. At 2^ERR_W-1 the count stays there.
- R8: An error event and a leak pulse in the same cycle leave `errCount` unchanged.
- R9: While either threshold field is zero (the all-zero configuration included), the timer is held at zero, the secondary divider is cleared and no leak pulse appears. After re-enabling, the first pulse follows the R4 timing from zero.
- R10: A synchronous active-high `rst` clears the timer, the secondary divider, `leakPulse` and `errCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| threshHi | input | UPPER_W | One-hot pick of the first match bit |
| threshLo | input | UPPER_W | One-hot pick of the second match bit |
| limitCode | input | LIMIT_W | Primary strobes per leak pulse (0 means 2^LIMIT_W) |
| errEvent | input | 1 | One correctable error in this cycle |
| leakPulse | output | 1 | One-cycle leak pulse |
| errCount | output | ERR_W | Current aged error count |
| upperLo | output | UPPER_W/2 | Low half of the upper timer counter |
| upperHi | output | UPPER_W-UPPER_W/2 | High half of the upper timer counter |

## Verification
An error increment and a leak decrement can land on the same clock edge. The count must then stay where it was. The bench waits for `leakPulse` to be observed high, raises `errEvent` in that same cycle, and requires the sampled count after the edge to equal the count before it. A long random stretch with frequent error events overlaps further increments with leak pulses. A bench-side saturating model, driven by the observed pulse and the applied event, judges every cycle of that stretch.

// File: rtl/ce_leak_pkg.sv
package ce_leak_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic timerRun;    // prescaler may count
    logic timerClear;  // whole timer returns to zero
    logic leak;        // one leak pulse for the error counter
  } leak_strobes_t;

endpackage

// File: rtl/ce_leak_datapath.sv
module ce_leak_datapath
  import ce_leak_pkg::*;
#(
  parameter int PRESC_W = 11,
  parameter int UPPER_W = 42,
  parameter int ERR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  leak_strobes_t       strobes,
  input  logic                errEvent,
  output logic [UPPER_W-1:0]  upperCnt,
  output logic [ERR_W-1:0]    errCount
);

  localparam logic [PRESC_W-1:0] PRESC_LAST = '1;
  localparam logic [ERR_W-1:0]   ERR_MAX    = '1;
  localparam logic [ERR_W-1:0]   ERR_MIN    = '0;

  logic [PRESC_W-1:0] prescCnt;
  logic               prescCarry;
  logic               incReq;
  logic               decReq;

  // Low-order prescaler: its wrap is the only thing that moves the upper part
  assign prescCarry = strobes.timerRun && (prescCnt == PRESC_LAST);

  always_ff @(posedge clk) begin
    if (rst || strobes.timerClear) begin
      prescCnt <= '0;
    end else if (strobes.timerRun) begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.timerClear) begin
      upperCnt <= '0;
    end else if (prescCarry) begin
      upperCnt <= upperCnt + 1'b1;
    end
  end

  // Saturating error counter; simultaneous up and down cancel
  assign incReq = errEvent && !strobes.leak;
  assign decReq = strobes.leak && !errEvent;

  always_ff @(posedge clk) begin
    if (rst) begin
      errCount <= '0;
    end else if (incReq && (errCount != ERR_MAX)) begin
      errCount <= errCount + 1'b1;
    end else if (decReq && (errCount != ERR_MIN)) begin
      errCount <= errCount - 1'b1;
    end
  end

endmodule

// File: rtl/ce_leak_control.sv
module ce_leak_control
  import ce_leak_pkg::*;
#(
  parameter int UPPER_W = 42,
  parameter int LIMIT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [UPPER_W-1:0]  threshHi,
  input  logic [UPPER_W-1:0]  threshLo,
  input  logic [LIMIT_W-1:0]  limitCode,
  input  logic [UPPER_W-1:0]  upperCnt,
  output leak_strobes_t       strobes,
  output logic                primaryStrobe
);

  localparam int SEC_W = LIMIT_W + 1;
  localparam logic [SEC_W-1:0] FULL_LIMIT = SEC_W'(1) << LIMIT_W;

  logic [UPPER_W-1:0] hiHit;
  logic [UPPER_W-1:0] loHit;
  logic               leakEnable;
  logic [SEC_W-1:0]   limitDecoded;
  logic [SEC_W-1:0]   secCnt;
  logic [SEC_W-1:0]   secNext;
  logic               leakQ;

  // Per-bit selection of the upper counter by each one-hot field
  for (genvar b = 0; b < UPPER_W; b++) begin : g_bitsel
    assign hiHit[b] = upperCnt[b] & threshHi[b];
    assign loHit[b] = upperCnt[b] & threshLo[b];
  end

  assign leakEnable    = (|threshHi) & (|threshLo);
  assign primaryStrobe = leakEnable & (|hiHit) & (|loHit);

  // Code zero stands for the largest group size
  assign limitDecoded = (limitCode == '0) ? FULL_LIMIT : SEC_W'(limitCode);
  assign secNext      = secCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      secCnt <= '0;
      leakQ  <= 1'b0;
    end else begin
      leakQ <= 1'b0;
      if (!leakEnable) begin
        secCnt <= '0;
      end else if (primaryStrobe) begin
        if (secNext >= limitDecoded) begin
          secCnt <= '0;
          leakQ  <= 1'b1;
        end else begin
          secCnt <= secNext;
        end
      end
    end
  end

  assign strobes.timerRun   = leakEnable;
  assign strobes.timerClear = primaryStrobe | ~leakEnable;
  assign strobes.leak       = leakQ;

endmodule

// File: rtl/ce_leaky_bucket.sv
module ce_leaky_bucket
  import ce_leak_pkg::*;
#(
  parameter int PRESC_W = 11,
  parameter int UPPER_W = 42,
  parameter int LIMIT_W = 2,
  parameter int ERR_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [UPPER_W-1:0]             threshHi,
  input  logic [UPPER_W-1:0]             threshLo,
  input  logic [LIMIT_W-1:0]             limitCode,
  input  logic                           errEvent,
  output logic                           leakPulse,
  output logic [ERR_W-1:0]               errCount,
  output logic [UPPER_W/2-1:0]           upperLo,
  output logic [UPPER_W-UPPER_W/2-1:0]   upperHi
);

  localparam int HALF_LO = UPPER_W / 2;

  leak_strobes_t      strobes;
  logic               primaryStrobe;
  logic [UPPER_W-1:0] upperCnt;

  ce_leak_control #(
    .UPPER_W (UPPER_W),
    .LIMIT_W (LIMIT_W)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .threshHi      (threshHi),
    .threshLo      (threshLo),
    .limitCode     (limitCode),
    .upperCnt      (upperCnt),
    .strobes       (strobes),
    .primaryStrobe (primaryStrobe)
  );

  ce_leak_datapath #(
    .PRESC_W (PRESC_W),
    .UPPER_W (UPPER_W),
    .ERR_W   (ERR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .errEvent (errEvent),
    .upperCnt (upperCnt),
    .errCount (errCount)
  );

  assign leakPulse = strobes.leak;
  assign upperLo   = upperCnt[HALF_LO-1:0];
  assign upperHi   = upperCnt[UPPER_W-1:HALF_LO];

endmodule

// File: rtl/ce_leak_checker.sv
module ce_leak_checker #(
  parameter int UPPER_W = 42,
  parameter int ERR_W   = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [UPPER_W-1:0]            threshHi,
  input logic [UPPER_W-1:0]            threshLo,
  input logic                          primaryStrobe,
  input logic                          leakPulse,
  input logic                          errEvent,
  input logic [ERR_W-1:0]              errCount,
  input logic [UPPER_W/2-1:0]          upperLo,
  input logic [UPPER_W-UPPER_W/2-1:0]  upperHi
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic enabled;
  logic timerZero;
  assign enabled   = (|threshHi) && (|threshLo);
  assign timerZero = (upperLo == '0) && (upperHi == '0);

  p_match_clears_r3: assert property (@(posedge clk) disable iff (rst)
    primaryStrobe |=> timerZero);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> (timerZero && !leakPulse));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    leakPulse |=> !leakPulse);

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(leakPulse) |-> $past(primaryStrobe));

  p_leak_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (leakPulse && !errEvent && errCount != '0) |=> errCount == $past(errCount) - 1'b1);

  p_leak_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (leakPulse && !errEvent && errCount == '0) |=> errCount == '0);

  p_err_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (errEvent && !leakPulse && errCount != ERR_MAX) |=> errCount == $past(errCount) + 1'b1);

  p_err_ceil_r7: assert property (@(posedge clk) disable iff (rst)
    (errEvent && !leakPulse && errCount == ERR_MAX) |=> errCount == ERR_MAX);

  p_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (errEvent && leakPulse) |=> $stable(errCount));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (errCount == '0 && !leakPulse && timerZero));

endmodule

bind ce_leaky_bucket ce_leak_checker #(
  .UPPER_W (UPPER_W),
  .ERR_W   (ERR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .threshHi      (threshHi),
  .threshLo      (threshLo),
  .primaryStrobe (primaryStrobe),
  .leakPulse     (leakPulse),
  .errEvent      (errEvent),
  .errCount      (errCount),
  .upperLo       (upperLo),
  .upperHi       (upperHi)
);

// File: tb/ce_leaky_bucket_tb.sv
module ce_leaky_bucket_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UPPER_W    = 42;
  localparam int PRESC_W    = 11;
  localparam int LIMIT_W    = 2;
  localparam int ERR_W      = 4;
  localparam int HALF       = UPPER_W / 2;
  localparam int STEP       = 1 << PRESC_W;
  localparam int PERIOD1    = STEP + 1;
  localparam int ERR_TOP    = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [UPPER_W-1:0] threshHi = '0;
  logic [UPPER_W-1:0] threshLo = '0;
  logic [LIMIT_W-1:0] limitCode = '0;
  logic errEvent = 1'b0;
  logic leakPulse;
  logic [ERR_W-1:0] errCount;
  logic [HALF-1:0] upperLo;
  logic [UPPER_W-HALF-1:0] upperHi;

  int checks = 0;
  int errors = 0;
  int pulseCount = 0;
  bit done = 1'b0;

  ce_leaky_bucket #(
    .PRESC_W (PRESC_W), .UPPER_W (UPPER_W), .LIMIT_W (LIMIT_W), .ERR_W (ERR_W)
  ) u_dut (
    .clk (clk), .rst (rst), .threshHi (threshHi), .threshLo (threshLo),
    .limitCode (limitCode), .errEvent (errEvent), .leakPulse (leakPulse),
    .errCount (errCount), .upperLo (upperLo), .upperHi (upperHi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (leakPulse === 1'b1) pulseCount++;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic setCfg(input int hiBit, input int loBit, input logic [LIMIT_W-1:0] code);
    @(negedge clk);
    threshHi  = (hiBit < 0) ? '0 : (UPPER_W'(1) << hiBit);
    threshLo  = (loBit < 0) ? '0 : (UPPER_W'(1) << loBit);
    limitCode = code;
  endtask

  function automatic int limitOf(input logic [LIMIT_W-1:0] c);
    return (c == '0) ? (1 << LIMIT_W) : int'(c);
  endfunction

  function automatic int nextErr(input int cur, input bit ev, input bit lp);
    if (ev && !lp) return (cur == ERR_TOP) ? cur : cur + 1;
    if (lp && !ev) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R4 / R5 / R6: exact pulse timing for one limit code, both thresholds on bit 0
  task automatic pulseTrain(input logic [LIMIT_W-1:0] code);
    int lim;
    int c;
    lim = limitOf(code);
    setCfg(-1, -1, code);
    tick(2);
    setCfg(0, 0, code);
    tick(lim * PERIOD1 - 1);
    check(leakPulse == 1'b0, "R4 no early pulse", leakPulse, 0);
    tick(1);
    check(leakPulse == 1'b1, "R4 first pulse", leakPulse, 1);
    c = int'(errCount);
    tick(1);
    check(leakPulse == 1'b0, "R5 pulse width", leakPulse, 0);
    check(int'(errCount) == nextErr(c, 1'b0, 1'b1), "R6 decrement", errCount, nextErr(c, 1'b0, 1'b1));
    tick(lim * PERIOD1 - 2);
    check(leakPulse == 1'b0, "R4 gap", leakPulse, 0);
    tick(1);
    check(leakPulse == 1'b1, "R4 spacing", leakPulse, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int expv;
    int p0;
    int c;
    bit found;
    void'($urandom(32'd4417));

    // R10 reset state
    doReset();
    #1;
    check(errCount == '0, "R10 count", errCount, 0);
    check(leakPulse == 1'b0, "R10 pulse", leakPulse, 0);
    check(upperLo == '0 && upperHi == '0, "R10 timer", upperLo, 0);

    // R1 / R2 / R3: both thresholds on bit 1, match at upper == 2
    setCfg(1, 1, 2'b01);
    tick(STEP - 1);
    check(upperLo == 0, "R1 before carry", upperLo, 0);
    tick(1);
    check(upperLo == 1, "R1 first carry", upperLo, 1);
    tick(STEP);
    check(upperLo == 2, "R1 second carry", upperLo, 2);
    check(upperHi == 0, "R2 high half", upperHi, 0);
    tick(1);
    check(upperLo == 0, "R3 timer cleared", upperLo, 0);
    check(leakPulse == 1'b1, "R5 pulse after strobe", leakPulse, 1);

    // R7 saturation at top with leaking off
    setCfg(-1, -1, 2'b00);
    tick(2);
    expv = int'(errCount);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); errEvent = 1'b1;
      expv = nextErr(expv, 1'b1, 1'b0);
      tick(1);
      check(int'(errCount) == expv, "R7 increment", errCount, expv);
    end
    @(negedge clk); errEvent = 1'b0;
    check(int'(errCount) == ERR_TOP, "R7 ceiling", errCount, ERR_TOP);

    // R4 each limit code
    pulseTrain(2'b01);
    pulseTrain(2'b10);
    pulseTrain(2'b11);
    pulseTrain(2'b00);

    // R9 disable clears timer and divider
    setCfg(-1, -1, 2'b00);
    tick(2);
    setCfg(0, 0, 2'b00);
    tick(2 * PERIOD1 + 5);
    setCfg(-1, -1, 2'b00);
    tick(1);
    p0 = pulseCount;
    tick(3000);
    check(upperLo == 0 && upperHi == 0, "R9 timer held", upperLo, 0);
    check(pulseCount == p0, "R9 no pulses", pulseCount, p0);
    setCfg(0, 0, 2'b00);
    tick(4 * PERIOD1 - 1);
    check(leakPulse == 1'b0, "R9 divider restarted", leakPulse, 0);
    tick(1);
    check(leakPulse == 1'b1, "R9 first pulse", leakPulse, 1);

    // R8 error event coinciding with a leak pulse
    setCfg(0, 0, 2'b01);
    found = 1'b0;
    for (int i = 0; i < 3 * PERIOD1 && !found; i++) begin
      tick(1);
      if (leakPulse) found = 1'b1;
    end
    check(found, "R8 pulse seen", found, 1);
    errEvent = 1'b1;
    c = int'(errCount);
    tick(1);
    errEvent = 1'b0;
    check(int'(errCount) == c, "R8 hold", errCount, c);

    // R10 reset again, then R6 floor at zero
    doReset();
    #1;
    check(errCount == '0, "R10 count cleared", errCount, 0);
    tick(PERIOD1);
    check(leakPulse == 1'b1, "R6 pulse at zero", leakPulse, 1);
    tick(1);
    check(errCount == '0, "R6 floor", errCount, 0);

    // Random events mixed with leaks, R6/R7/R8 model
    setCfg(0, 0, 2'b10);
    expv = 0;
    for (int i = 0; i < 12000; i++) begin
      bit lp;
      @(negedge clk);
      errEvent = (($urandom % 3) == 0);
      lp = leakPulse;
      expv = nextErr(expv, errEvent, lp);
      @(posedge clk); #1;
      check(int'(errCount) == expv, "R7 R6 R8 random", errCount, expv);
    end
    @(negedge clk); errEvent = 1'b0;

    done = 1'b1;
    summary();
  end

endmodule